// File: doc/BRIEF.md
# Subroutine Call Bus Sequencer

This block is a minimal 8-bit bus master that carries out one instruction, the subroutine call, with the same bus activity in every cycle as a classic 8-bit microprocessor. Each clock is one bus cycle. In each cycle it drives a 16-bit address and a read/write strobe, and it drives an 8-bit write value or samples an 8-bit read value. It keeps a 16-bit program counter and an 8-bit stack pointer. The stack pointer selects a byte within a fixed stack page. Any opcode other than the call opcode runs as a two-cycle, one-byte no-operation.

The block exists for bus-watching tools that decode instructions from the data bus alone. A call does not fetch its third instruction byte straight after the second. That byte is read only after a dummy stack read and the two stack writes. The return address pushed to the stack is therefore the address of the third byte. A sync output marks every opcode fetch, so that an observer can find where each instruction starts.

Top module: `subcall_seq`

## Requirements
- R1: A synchronous active-high reset loads the program counter with the `RESET_PC` parameter and the stack pointer with 0xFF, including when it arrives partway through a call. While reset is held, rdWr is 1, sync is 0 and dataOut is 0x00. The first cycle after reset is released is an opcode fetch at `RESET_PC`.
- R2: When the byte fetched in cycle 1 (read at PC, sync high) equals 0x20, a call starts. Cycle 2 reads the low target byte at PC+1.
- R3: Cycle 3 of a call is a read at 0x0100+SP. The byte returned in that cycle has no effect on any later address or on any pushed value.
- R4: Cycle 4 writes the high byte of PC+2 to 0x0100+SP. Cycle 5 writes the low byte of PC+2 to 0x0100+SP-1, where the subtraction is taken modulo 256.
- R5: Cycle 6 reads the high target byte at PC+2. Cycle 7 is an opcode fetch at the address whose high byte is the cycle 6 data and whose low byte is the cycle 2 data.
- R6: Each call lowers SP by 2, modulo 256. The high address byte of every stack access is 0x01. After reset, the 129th consecutive call pushes to 0x01FF and then 0x01FE.
- R7: rdWr is 0 (write) only in cycles 4 and 5 of a call and is 1 in every other cycle. dataOut is 0x00 in every read cycle.
- R8: An opcode other than 0x20 takes two cycles: the fetch at PC, then a read at PC+1 whose data is ignored, even when that data is 0x20. The next fetch is at PC+1.
- R9: sync is 1 in exactly the opcode fetch cycles and is never 1 in two consecutive cycles.
- R10: All program-counter arithmetic wraps modulo 65536. For example, a one-byte opcode at 0xFFFF is followed by a fetch at 0x0000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock; one bus cycle per rising edge |
| rst | input | 1 | Synchronous active-high reset |
| dataIn | input | 8 | Read data, sampled at the end of each read cycle |
| addr | output | 16 | Bus address of the current cycle |
| dataOut | output | 8 | Write data; 0x00 during read cycles |
| rdWr | output | 1 | 1 = read cycle, 0 = write cycle |
| sync | output | 1 | 1 during opcode fetch cycles |

## Verification
The bench builds the block with `RESET_PC` = 0x2000, call opcode 0x20, stack page 0x01 and 8-bit data. With these values the first call can be compared against the well-known six-cycle trace at 0x2000 with SP = 0xFF. A call placed at 0xFF00 and one-byte opcodes at 0xFFFE and 0xFFFF drive the program counter across the top of the 16-bit space. Because the stack pointer is only 8 bits wide, 129 back-to-back calls after a reset are enough to wrap SP from 0x01 back to 0xFF and confirm that the pushes stay inside page one.

// File: rtl/subcall_pkg.sv
package subcall_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH,
    ST_TGT_LO,
    ST_STK_RD,
    ST_PUSH_HI,
    ST_PUSH_LO,
    ST_TGT_HI,
    ST_SKIP
  } seqState_t;

  typedef enum logic {
    SRC_PC,
    SRC_STACK
  } addrSrc_t;

  typedef struct packed {
    addrSrc_t addrSrc;
    logic     writeCyc;
    logic     pushHigh;
    logic     incPc;
    logic     latchLo;
    logic     jumpPc;
    logic     decSp;
    logic     fetchCyc;
  } dpStrobe_t;

endpackage

// File: rtl/subcall_ctrl.sv
module subcall_ctrl
  import subcall_pkg::*;
#(
  parameter int              DATA_W  = 8,
  parameter logic [DATA_W-1:0] CALL_OP = 8'h20
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] dataIn,
  output dpStrobe_t         strobe
);

  seqState_t state;
  seqState_t nextState;

  always_ff @(posedge clk) begin
    if (rst) state <= ST_IDLE;
    else     state <= nextState;
  end

  always_comb begin
    strobe         = '0;
    strobe.addrSrc = SRC_PC;
    nextState      = state;
    case (state)
      ST_IDLE: begin
        nextState = ST_FETCH;
      end
      ST_FETCH: begin
        strobe.fetchCyc = 1'b1;
        strobe.incPc    = 1'b1;
        nextState       = (dataIn == CALL_OP) ? ST_TGT_LO : ST_SKIP;
      end
      ST_SKIP: begin
        nextState = ST_FETCH;
      end
      ST_TGT_LO: begin
        strobe.latchLo = 1'b1;
        strobe.incPc   = 1'b1;
        nextState      = ST_STK_RD;
      end
      ST_STK_RD: begin
        strobe.addrSrc = SRC_STACK;
        nextState      = ST_PUSH_HI;
      end
      ST_PUSH_HI: begin
        strobe.addrSrc  = SRC_STACK;
        strobe.writeCyc = 1'b1;
        strobe.pushHigh = 1'b1;
        strobe.decSp    = 1'b1;
        nextState       = ST_PUSH_LO;
      end
      ST_PUSH_LO: begin
        strobe.addrSrc  = SRC_STACK;
        strobe.writeCyc = 1'b1;
        strobe.decSp    = 1'b1;
        nextState       = ST_TGT_HI;
      end
      ST_TGT_HI: begin
        strobe.jumpPc = 1'b1;
        nextState     = ST_FETCH;
      end
      default: begin
        nextState = ST_IDLE;
      end
    endcase
  end

endmodule

// File: rtl/subcall_dp.sv
module subcall_dp
  import subcall_pkg::*;
#(
  parameter int                  DATA_W     = 8,
  parameter logic [2*DATA_W-1:0] RESET_PC   = 16'h2000,
  parameter logic [DATA_W-1:0]   STACK_PAGE = 8'h01,
  parameter logic [DATA_W-1:0]   SP_INIT    = 8'hFF
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [DATA_W-1:0]   dataIn,
  input  dpStrobe_t           strobe,
  output logic [2*DATA_W-1:0] addr,
  output logic [DATA_W-1:0]   dataOut,
  output logic                rdWr,
  output logic                sync
);

  localparam int ADDR_W = 2 * DATA_W;
  localparam logic [ADDR_W-1:0] PC_ONE = 1;
  localparam logic [DATA_W-1:0] SP_ONE = 1;

  logic [ADDR_W-1:0] pc;
  logic [DATA_W-1:0] sp;
  logic [DATA_W-1:0] tgtLo;

  always_ff @(posedge clk) begin
    if (rst) begin
      pc <= RESET_PC;
    end else if (strobe.jumpPc) begin
      pc <= {dataIn, tgtLo};
    end else if (strobe.incPc) begin
      pc <= pc + PC_ONE;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)               sp <= SP_INIT;
    else if (strobe.decSp) sp <= sp - SP_ONE;
  end

  always_ff @(posedge clk) begin
    if (rst)                 tgtLo <= '0;
    else if (strobe.latchLo) tgtLo <= dataIn;
  end

  always_comb begin
    addr = (strobe.addrSrc == SRC_STACK) ? {STACK_PAGE, sp} : pc;
    if (strobe.writeCyc)
      dataOut = strobe.pushHigh ? pc[ADDR_W-1:DATA_W] : pc[DATA_W-1:0];
    else
      dataOut = '0;
    rdWr = ~strobe.writeCyc;
    sync = strobe.fetchCyc;
  end

endmodule

// File: rtl/subcall_seq.sv
module subcall_seq
  import subcall_pkg::*;
#(
  parameter int                  DATA_W     = 8,
  parameter logic [2*DATA_W-1:0] RESET_PC   = 16'h2000,
  parameter logic [DATA_W-1:0]   CALL_OP    = 8'h20,
  parameter logic [DATA_W-1:0]   STACK_PAGE = 8'h01
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [DATA_W-1:0]   dataIn,
  output logic [2*DATA_W-1:0] addr,
  output logic [DATA_W-1:0]   dataOut,
  output logic                rdWr,
  output logic                sync
);

  localparam logic [DATA_W-1:0] SP_INIT = '1;

  dpStrobe_t strobe;

  subcall_ctrl #(
    .DATA_W (DATA_W),
    .CALL_OP(CALL_OP)
  ) u_ctrl (
    .clk   (clk),
    .rst   (rst),
    .dataIn(dataIn),
    .strobe(strobe)
  );

  subcall_dp #(
    .DATA_W    (DATA_W),
    .RESET_PC  (RESET_PC),
    .STACK_PAGE(STACK_PAGE),
    .SP_INIT   (SP_INIT)
  ) u_dp (
    .clk    (clk),
    .rst    (rst),
    .dataIn (dataIn),
    .strobe (strobe),
    .addr   (addr),
    .dataOut(dataOut),
    .rdWr   (rdWr),
    .sync   (sync)
  );

endmodule

// File: rtl/subcall_seq_chk.sv
module subcall_seq_chk #(
  parameter int                DATA_W     = 8,
  parameter logic [DATA_W-1:0] STACK_PAGE = 8'h01
) (
  input logic                clk,
  input logic                rst,
  input logic [2*DATA_W-1:0] addr,
  input logic [DATA_W-1:0]   dataOut,
  input logic                rdWr,
  input logic                sync
);

  localparam logic [DATA_W-1:0] ONE = 1;

  // R6
  write_in_stack_page_chk: assert property (@(posedge clk) disable iff (rst)
    !rdWr |-> addr[2*DATA_W-1:DATA_W] == STACK_PAGE);

  // R7
  read_data_zero_chk: assert property (@(posedge clk) disable iff (rst)
    rdWr |-> dataOut == '0);

  // R4
  push_addr_step_chk: assert property (@(posedge clk) disable iff (rst)
    (!rdWr && !$past(rdWr)) |-> addr[DATA_W-1:0] == $past(addr[DATA_W-1:0]) - ONE);

  // R7
  write_pair_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rdWr) |=> !rdWr);

  // R7
  write_pair_end_chk: assert property (@(posedge clk) disable iff (rst)
    (!rdWr && !$past(rdWr)) |=> rdWr);

  // R9
  sync_is_read_chk: assert property (@(posedge clk) disable iff (rst)
    sync |-> rdWr);

  // R9
  sync_single_chk: assert property (@(posedge clk) disable iff (rst)
    sync |=> !sync);

  // R5
  fetch_after_tgt_hi_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(rdWr) |=> sync);

endmodule

bind subcall_seq subcall_seq_chk #(
  .DATA_W    (DATA_W),
  .STACK_PAGE(STACK_PAGE)
) u_chk (
  .clk    (clk),
  .rst    (rst),
  .addr   (addr),
  .dataOut(dataOut),
  .rdWr   (rdWr),
  .sync   (sync)
);

// File: tb/sim_subcall_seq.sv
module sim_subcall_seq;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  dataIn = 8'h00;
  logic [15:0] addr;
  logic [7:0]  dataOut;
  logic        rdWr;
  logic        sync;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  subcall_seq #(
    .DATA_W    (8),
    .RESET_PC  (16'h2000),
    .CALL_OP   (8'h20),
    .STACK_PAGE(8'h01)
  ) u0 (
    .clk    (clk),
    .rst    (rst),
    .dataIn (dataIn),
    .addr   (addr),
    .dataOut(dataOut),
    .rdWr   (rdWr),
    .sync   (sync)
  );

  // {req[3:0], addr[15:0], rdWr, dataOut[7:0], sync, dataIn to drive[7:0]}
  localparam int NV = 27;
  localparam logic [37:0] VEC [0:NV-1] = '{
    {4'd2,  16'h2000, 1'b1, 8'h00, 1'b1, 8'h20}, // R2 fetch call
    {4'd2,  16'h2001, 1'b1, 8'h00, 1'b0, 8'h34}, // R2 low target
    {4'd3,  16'h01FF, 1'b1, 8'h00, 1'b0, 8'hA5}, // R3 dummy stack read
    {4'd4,  16'h01FF, 1'b0, 8'h20, 1'b0, 8'h00}, // R4 push high
    {4'd4,  16'h01FE, 1'b0, 8'h02, 1'b0, 8'h00}, // R4 push low
    {4'd5,  16'h2002, 1'b1, 8'h00, 1'b0, 8'h12}, // R5 high target
    {4'd5,  16'h1234, 1'b1, 8'h00, 1'b1, 8'hEA}, // R5 fetch at target
    {4'd8,  16'h1235, 1'b1, 8'h00, 1'b0, 8'hFF}, // R8 dummy read
    {4'd8,  16'h1235, 1'b1, 8'h00, 1'b1, 8'h20}, // R8 next fetch at PC+1
    {4'd2,  16'h1236, 1'b1, 8'h00, 1'b0, 8'h00}, // R2
    {4'd6,  16'h01FD, 1'b1, 8'h00, 1'b0, 8'h77}, // R6 SP lowered by 2
    {4'd4,  16'h01FD, 1'b0, 8'h12, 1'b0, 8'h00}, // R4
    {4'd4,  16'h01FC, 1'b0, 8'h37, 1'b0, 8'h00}, // R4
    {4'd5,  16'h1237, 1'b1, 8'h00, 1'b0, 8'hFF}, // R5
    {4'd5,  16'hFF00, 1'b1, 8'h00, 1'b1, 8'h20}, // R5 fetch high page
    {4'd2,  16'hFF01, 1'b1, 8'h00, 1'b0, 8'hFE}, // R2
    {4'd3,  16'h01FB, 1'b1, 8'h00, 1'b0, 8'h00}, // R3
    {4'd4,  16'h01FB, 1'b0, 8'hFF, 1'b0, 8'h00}, // R4
    {4'd4,  16'h01FA, 1'b0, 8'h02, 1'b0, 8'h00}, // R4
    {4'd5,  16'hFF02, 1'b1, 8'h00, 1'b0, 8'hFF}, // R5
    {4'd9,  16'hFFFE, 1'b1, 8'h00, 1'b1, 8'h00}, // R9 fetch
    {4'd7,  16'hFFFF, 1'b1, 8'h00, 1'b0, 8'h00}, // R7 read cycle
    {4'd10, 16'hFFFF, 1'b1, 8'h00, 1'b1, 8'h13}, // R10 fetch at top
    {4'd10, 16'h0000, 1'b1, 8'h00, 1'b0, 8'h20}, // R10 wrap; R8 0x20 ignored
    {4'd8,  16'h0000, 1'b1, 8'h00, 1'b1, 8'h00}, // R8 fetch, not call
    {4'd8,  16'h0001, 1'b1, 8'h00, 1'b0, 8'h00}, // R8
    {4'd9,  16'h0001, 1'b1, 8'h00, 1'b1, 8'h20}  // R9 fetch call
  };

  task automatic stepCycle(input int req, input logic [15:0] expAddr,
                           input logic expRw, input logic [7:0] expDout,
                           input logic expSync, input logic [7:0] din);
    @(negedge clk);
    checks++;
    if (addr !== expAddr || rdWr !== expRw || dataOut !== expDout || sync !== expSync) begin
      fails++;
      $display("FAIL R%0d: addr=%h rdWr=%b dataOut=%h sync=%b, expected addr=%h rdWr=%b dataOut=%h sync=%b",
               req, addr, rdWr, dataOut, sync, expAddr, expRw, expDout, expSync);
    end
    dataIn = din;
  endtask

  task automatic checkResetOutputs();
    checks++;
    // R1 outputs while reset is held
    if (rdWr !== 1'b1 || sync !== 1'b0 || dataOut !== 8'h00) begin
      fails++;
      $display("FAIL R1: rdWr=%b sync=%b dataOut=%h, expected rdWr=1 sync=0 dataOut=00",
               rdWr, sync, dataOut);
    end
  endtask

  task automatic doCall(input int n);
    logic [7:0] spHi;
    logic [7:0] spLo;
    spHi = 8'hFF - 8'(2 * n);
    spLo = spHi - 8'd1;
    stepCycle(2, 16'h2000, 1'b1, 8'h00, 1'b1, 8'h20);
    stepCycle(2, 16'h2001, 1'b1, 8'h00, 1'b0, 8'h00);
    stepCycle(6, {8'h01, spHi}, 1'b1, 8'h00, 1'b0, 8'h5A); // R6
    stepCycle(6, {8'h01, spHi}, 1'b0, 8'h20, 1'b0, 8'h00);
    stepCycle(6, {8'h01, spLo}, 1'b0, 8'h02, 1'b0, 8'h00);
    stepCycle(5, 16'h2002, 1'b1, 8'h00, 1'b0, 8'h20);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    checkResetOutputs();
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      stepCycle(int'(VEC[i][37:34]), VEC[i][33:18], VEC[i][17],
                VEC[i][16:9], VEC[i][8], VEC[i][7:0]);
    end

    // R1: reset in the middle of a call (SP is 0xF9 here)
    stepCycle(2, 16'h0002, 1'b1, 8'h00, 1'b0, 8'h44);
    stepCycle(3, 16'h01F9, 1'b1, 8'h00, 1'b0, 8'h99);
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    checkResetOutputs();
    rst = 1'b0;

    // R1 then R6: the first call after reset pushes at 0x01FF; the 129th wraps back there
    for (int n = 0; n < 129; n++) begin
      doCall(n);
    end
    stepCycle(5, 16'h2000, 1'b1, 8'h00, 1'b1, 8'hEA);
    stepCycle(8, 16'h2001, 1'b1, 8'h00, 1'b0, 8'h00);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run did not complete, expected completion within 20000 cycles");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule